// File: doc/BRIEF.md
# Counter Timebase and Mode Controller

This block is the front end of a programmable counter array. It holds an 8-bit mode register and uses it to decide, in every system-clock cycle, whether the shared 16-bit counter advances. There are eight possible count-enable sources: three prescaled forms of the system clock, three timer-overflow strobes, falling edges of an external count pin, and an external clock divided by eight. Both external pins are synchronized before use. The mode register can also freeze counting while the CPU is idle. It masks the overflow interrupt and carries a watchdog-enable bit with a sticky lock.

While the watchdog-enable bit is set, the rest of the mode register is write-protected. The lock bit, once set, keeps the watchdog enabled until reset. When the counter wraps from its all-ones value, a sticky overflow flag is set. Software clears that flag with a dedicated clear strobe.

Top module: `ctb_top`

## Requirements
- R1: After reset the mode register reads 0x40, the counter reads 0, and the overflow flag and interrupt request are both 0.
- R2: Mode bit 4 always reads 0, and a write of 1 to it has no effect.
- R3: The counter advances by exactly 1 on each enabled cycle. Mode bits [3:1] select the source: code 100 enables every cycle, code 001 enables every 4th cycle, and code 000 enables every 12th cycle. The /4 and /12 dividers run freely from reset, so the first enable comes in the 4th or 12th cycle after reset release.
- R4: With code 010, 110 or 111, the counter advances once per cycle in which the overflow strobe of timer 0, 4 or 5 is high, and ignores the other two strobes.
- R5: With code 011, the counter advances once for each high-to-low transition of the external count input. The input passes through two synchronizer flops, so the counter changes on the 3rd rising clock edge after the low level is first sampled.
- R6: With code 101, the counter advances once for every 8th rising transition of the synchronized external clock. The divide-by-8 counter starts from reset.
- R7: When mode bit 7 is 1 and the idle input is high, no count occurs. When bit 7 is 0, the idle input has no effect.
- R8: A count from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until the clear strobe is applied. A new overflow in the same cycle as a clear wins.
- R9: The interrupt request equals the overflow flag ANDed with mode bit 0.
- R10: While mode bit 6 (watchdog enable) is 1, a write cannot change bits 7, 5, 3:1 or 0. If the lock is clear, the write copies its own bit 6 into bit 6. So a write with bit 6 at 0 clears the watchdog enable and leaves every other bit unchanged.
- R11: Mode bit 5 (lock) is set-only until reset, and can be set only by a write made while bit 6 is 0. While the lock is 1, bit 6 cannot return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released in step with clk |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| mode_q | output | 8 | Mode register contents |
| cpu_idle | input | 1 | High while the CPU is in idle |
| ext_cnt_in | input | 1 | Asynchronous external count input (falling edges count) |
| ext_clk_in | input | 1 | Asynchronous external clock (divided by 8) |
| tmr0_ovf | input | 1 | Timer 0 overflow strobe |
| tmr4_ovf | input | 1 | Timer 4 overflow strobe |
| tmr5_ovf | input | 1 | Timer 5 overflow strobe |
| ovf_clr | input | 1 | Clears the overflow flag |
| count_q | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
A reference model is compared with the design on every clock. It is driven with each of the eight source codes in turn:
- The free-running clock codes show whether the /4 and /12 phase and the counting step are right.
- Interleaved pulses on all three timer strobes show whether the correct strobe was chosen.
- Toggling of the external count pin at the highest allowed rate reveals errors in synchronizer delay and in which edge polarity is counted.
- A slower toggling external clock tests the divide-by-8 phase.

Further patterns check the idle gating and the overflow, flag-clear and mask interactions. A sequence of protected, unlocking and locked writes separates the write-protection rule from the lock rule.

// File: rtl/ctb_pkg.sv
package ctb_pkg;

  typedef enum logic [2:0] {
    SRC_DIV12   = 3'b000,
    SRC_DIV4    = 3'b001,
    SRC_TMR0    = 3'b010,
    SRC_EXTFALL = 3'b011,
    SRC_SYSCLK  = 3'b100,
    SRC_EXTDIV8 = 3'b101,
    SRC_TMR4    = 3'b110,
    SRC_TMR5    = 3'b111
  } ctb_src_e;

  typedef struct packed {
    logic     idle_susp;  // bit 7
    logic     wd_en;      // bit 6
    logic     wd_lock;    // bit 5
    logic     rsvd;       // bit 4
    ctb_src_e src;        // bits 3:1
    logic     ovf_ie;     // bit 0
  } ctb_mode_t;

  localparam ctb_mode_t MODE_RST = '{idle_susp: 1'b0, wd_en: 1'b1, wd_lock: 1'b0,
                                     rsvd: 1'b0, src: SRC_DIV12, ovf_ie: 1'b0};

endpackage

// File: rtl/ctb_pulse_div.sv
module ctb_pulse_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic pulse_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign pulse_o = step_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_d;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R3
    end
  endgenerate

endmodule

// File: rtl/ctb_edge_sync.sv
module ctb_edge_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          FALLING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= level;
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = last_q & ~level;
    end else begin : g_rise
      assign edge_o = ~last_q & level;
    end
  endgenerate

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o); // R5

endmodule

// File: rtl/ctb_mode_reg.sv
module ctb_mode_reg
  import ctb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output ctb_mode_t  mode_o
);
  ctb_mode_t mode_q, mode_d, wr_val;

  assign wr_val = ctb_mode_t'(wr_data);
  assign mode_o = mode_q;

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      if (mode_q.wd_en) begin
        // protected: only the enable may drop, and only while unlocked
        if (!mode_q.wd_lock) begin
          mode_d.wd_en = wr_val.wd_en;
        end
      end else begin
        mode_d         = wr_val;
        mode_d.rsvd    = 1'b0;
        mode_d.wd_lock = mode_q.wd_lock | wr_val.wd_lock;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
    end else if (wr_en) begin
      mode_q <= mode_d;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.wd_lock |=> mode_q.wd_lock); // R11
  AST_LOCK_HOLDS_WDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.wd_lock && mode_q.wd_en) |=> mode_q.wd_en); // R11
  AST_WRITE_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.wd_en |=> ($stable(mode_q.idle_susp) && $stable(mode_q.src)
                      && $stable(mode_q.ovf_ie) && $stable(mode_q.wd_lock))); // R10
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !mode_q.rsvd); // R2

endmodule

// File: rtl/ctb_top.sv
module ctb_top
  import ctb_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SLOW_DIV    = 12,
  parameter int unsigned FAST_DIV    = 4,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       mode_q,
  input  logic             cpu_idle,
  input  logic             ext_cnt_in,
  input  logic             ext_clk_in,
  input  logic             tmr0_ovf,
  input  logic             tmr4_ovf,
  input  logic             tmr5_ovf,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_flag,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ctb_mode_t        mode;
  logic             slow_tick, fast_tick, ext_fall, extclk_rise, extclk_tick;
  logic             src_tick, suspend, cnt_en, wrap;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;

  ctb_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .mode_o  (mode)
  );

  ctb_pulse_div #(.DIV(SLOW_DIV)) u_div_slow (
    .clk(clk), .rst_n(rst_n), .step_i(1'b1), .pulse_o(slow_tick)
  );

  ctb_pulse_div #(.DIV(FAST_DIV)) u_div_fast (
    .clk(clk), .rst_n(rst_n), .step_i(1'b1), .pulse_o(fast_tick)
  );

  ctb_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_sync_cnt (
    .clk(clk), .rst_n(rst_n), .async_i(ext_cnt_in), .edge_o(ext_fall)
  );

  ctb_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk_in), .edge_o(extclk_rise)
  );

  ctb_pulse_div #(.DIV(EXT_DIV)) u_div_ext (
    .clk(clk), .rst_n(rst_n), .step_i(extclk_rise), .pulse_o(extclk_tick)
  );

  always_comb begin
    unique case (mode.src)
      SRC_DIV12:   src_tick = slow_tick;
      SRC_DIV4:    src_tick = fast_tick;
      SRC_TMR0:    src_tick = tmr0_ovf;
      SRC_EXTFALL: src_tick = ext_fall;
      SRC_SYSCLK:  src_tick = 1'b1;
      SRC_EXTDIV8: src_tick = extclk_tick;
      SRC_TMR4:    src_tick = tmr4_ovf;
      SRC_TMR5:    src_tick = tmr5_ovf;
      default:     src_tick = 1'b0;
    endcase
  end

  assign suspend = mode.idle_susp & cpu_idle;
  assign cnt_en  = src_tick & ~suspend;
  assign wrap    = cnt_en & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    flag_d = flag_q;
    if (ovf_clr) flag_d = 1'b0;
    if (wrap)    flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (wrap || ovf_clr) begin
      flag_q <= flag_d;
    end
  end

  assign mode_q   = mode;
  assign count_q  = cnt_q;
  assign ovf_flag = flag_q;
  assign irq      = flag_q & mode.ovf_ie;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> $stable(cnt_q)); // R7
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_MAX) && cnt_en) |=> (flag_q && cnt_q == '0)); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q); // R9

endmodule

// File: tb/tb_ctb_top.sv
module tb_ctb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, cpu_idle, ext_cnt_in, ext_clk_in;
  logic        tmr0_ovf, tmr4_ovf, tmr5_ovf, ovf_clr;
  logic [7:0]  wr_data, mode_q;
  logic [15:0] count_q;
  logic        ovf_flag, irq;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // reference state
  int   m_mode, m_cnt, m12, m4, m8;
  bit   m_flag;
  bit   ec1, ec2, ec3, ek1, ek2, ek3;

  always #2.5 clk = ~clk;  // 200 MHz

  ctb_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode_q(mode_q),
    .cpu_idle(cpu_idle), .ext_cnt_in(ext_cnt_in), .ext_clk_in(ext_clk_in),
    .tmr0_ovf(tmr0_ovf), .tmr4_ovf(tmr4_ovf), .tmr5_ovf(tmr5_ovf),
    .ovf_clr(ovf_clr), .count_q(count_q), .ovf_flag(ovf_flag), .irq(irq)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 'h40; m_cnt = 0; m_flag = 0; m12 = 0; m4 = 0; m8 = 0;
      ec1 = 0; ec2 = 0; ec3 = 0; ek1 = 0; ek2 = 0; ek3 = 0;
    end else begin
      bit tick, rise, wrapped;
      rise = !ek3 && ek2;
      case ((m_mode >> 1) & 7)
        0: tick = (m12 == 11);
        1: tick = (m4 == 3);
        2: tick = tmr0_ovf;
        3: tick = ec3 && !ec2;
        4: tick = 1;
        5: tick = rise && (m8 == 7);
        6: tick = tmr4_ovf;
        default: tick = tmr5_ovf;
      endcase
      if (rise) m8 = (m8 + 1) % 8;
      m12 = (m12 + 1) % 12;
      m4  = (m4 + 1) % 4;
      ec3 = ec2; ec2 = ec1; ec1 = ext_cnt_in;
      ek3 = ek2; ek2 = ek1; ek1 = ext_clk_in;
      wrapped = 0;
      if (tick && !(((m_mode >> 7) & 1) && cpu_idle)) begin
        if (m_cnt == 65535) begin m_cnt = 0; wrapped = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (wrapped) m_flag = 1;
      else if (ovf_clr) m_flag = 0;
      if (wr_en) begin
        if ((m_mode & 'h40) != 0) begin
          if ((m_mode & 'h20) == 0) m_mode = (m_mode & 'hBF) | (wr_data & 'h40);
        end else begin
          m_mode = (wr_data & 'hEF) | (m_mode & 'h20);
        end
      end
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      cmp("mode_q",   int'(mode_q),   m_mode);
      cmp("count_q",  int'(count_q),  m_cnt);
      cmp("ovf_flag", int'(ovf_flag), int'(m_flag));
      cmp("irq",      int'(irq),      int'(m_flag && (m_mode & 1)));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); #1; wr_en = 1'b1; wr_data = d;
    @(negedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at %s", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = 0; cpu_idle = 0; ext_cnt_in = 0;
    ext_clk_in = 0; tmr0_ovf = 0; tmr4_ovf = 0; tmr5_ovf = 0; ovf_clr = 0;
    step(3); rst_n = 1'b1;
    cur_req = "R1"; step(2);
    if (mode_q !== 8'h40) cmp("R1 reset mode", int'(mode_q), 'h40);

    cur_req = "R10"; wr(8'h08);   // protected: only watchdog enable drops
    step(2); cmp("R10 unlock keeps other bits", int'(mode_q), 'h00);

    cur_req = "R2"; wr(8'h18);    // bit 4 ignored, sysclk source
    cmp("R2 bit4 low", int'(mode_q[4]), 0);
    cur_req = "R3"; step(30);
    wr(8'h02); step(41);
    wr(8'h00); step(61);

    cur_req = "R4";
    for (int s = 0; s < 3; s++) begin
      wr(s == 0 ? 8'h04 : (s == 1 ? 8'h0C : 8'h0E));
      for (int i = 0; i < 36; i++) begin
        tmr0_ovf = (i % 3 == 0); tmr4_ovf = (i % 4 == 1); tmr5_ovf = (i % 5 == 2);
        step(1);
      end
      tmr0_ovf = 0; tmr4_ovf = 0; tmr5_ovf = 0;
    end

    cur_req = "R5"; wr(8'h06);
    for (int i = 0; i < 48; i++) begin ext_cnt_in = ((i / 2) % 2 == 1); step(1); end
    ext_cnt_in = 0; step(5);

    cur_req = "R6"; wr(8'h0A);
    for (int i = 0; i < 150; i++) begin ext_clk_in = ((i / 3) % 2 == 1); step(1); end
    ext_clk_in = 0; step(5);

    cur_req = "R7"; wr(8'h88);
    for (int i = 0; i < 40; i++) begin cpu_idle = (i % 7 < 3); step(1); end
    wr(8'h08);
    for (int i = 0; i < 20; i++) begin cpu_idle = 1'b1; step(1); end
    cpu_idle = 0;

    cur_req = "R8"; wr(8'h09);
    for (int i = 0; i < 70000 && !m_flag; i++) step(1);
    step(3); cmp("R8 flag set after wrap", int'(ovf_flag), 1);
    cur_req = "R9"; cmp("R9 irq with enable", int'(irq), 1);
    wr(8'h08); cmp("R9 irq masked", int'(irq), 0);
    cur_req = "R8"; cmp("R8 flag sticky", int'(ovf_flag), 1);
    ovf_clr = 1'b1; step(1); ovf_clr = 1'b0; step(1);
    cmp("R8 flag cleared", int'(ovf_flag), 0);

    cur_req = "R10"; wr(8'h48); wr(8'hC9); step(1);
    cmp("R10 protected write", int'(mode_q), 'h48);
    wr(8'h01); cmp("R10 clear only enable", int'(mode_q), 'h08);

    cur_req = "R11"; wr(8'h68); wr(8'h08); step(1);
    cmp("R11 locked enable held", int'(mode_q), 'h68);
    wr(8'h00); cmp("R11 lock sticky", int'(mode_q), 'h68);

    cur_req = "R1"; do_reset(); step(1);
    cmp("R1 reset clears lock", int'(mode_q), 'h40);
    step(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule